// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer and Commit Timer

This block sits behind a two-wire bus front end and models the storage side of a serial EEPROM. The front end hands it byte-level commands. It can set the word address, push one write byte, fetch one read byte, or mark the stop that closes a sequence. The block keeps the word address counter and gathers write bytes in a one-page staging buffer. Each staged byte has its own valid flag. The nonvolatile array is modelled as a plain RAM.

The stop that closes a write sequence starts the commit, provided at least one byte is staged and write protect is low. The commit moves the flagged bytes into the array. Busy stays high for a fixed number of cycles, which stands in for the nonvolatile programming time. While busy is high, every command is dropped. The array size, the page size and the write time are all parameters. The full-size device uses 17 address bits and 256-byte pages.

The controller has three states. ST_IDLE moves to ST_COPY when an accepted end command finds staged bytes and write protect low. In every other case ST_IDLE stays put. ST_COPY visits each page offset once, writes the flagged bytes and clears their flags. It moves to ST_HOLD after the last offset. ST_HOLD counts out the rest of the write time and returns to ST_IDLE when the counter reaches zero.

Top module: `eep_pagewr_top`

## Requirements
- R1: After reset, busy and rd_valid are low and the address counter is 0. A write byte sent with no address load lands at address 0.
- R2: cmd_op encodes 0 = load address, 1 = write byte, 2 = read byte, 3 = end of sequence. A read command taken on one clock edge makes rd_valid high, with rd_data equal to the array byte at the current address, from that edge until the next.
- R3: Each accepted read adds one to the full address. Reads therefore cross page boundaries, and the highest address is followed by address 0.
- R4: Each accepted write byte goes to the current offset in the staging buffer. Then only the low PAGE_W address bits step. A byte sent after the last offset of a page goes to offset 0 of the same page.
- R5: When more bytes than one page holds are sent in one sequence, the later bytes replace the earlier ones at the same offsets.
- R6: A commit changes only the offsets that were written. The other bytes of the page keep their old contents.
- R7: Staged bytes do not reach the array until an end command is accepted. Before that, a read returns the old contents.
- R8: An end command that starts a commit holds busy high for exactly max(WR_CYCLES, 2^PAGE_W + 1) cycles, counted from the edge after the command.
- R9: If wp is high when an end command is accepted, the staged bytes are discarded and busy stays low. A second end command after wp drops also commits nothing.
- R10: While busy is high, all commands are ignored. Reads give no rd_valid, address loads do nothing and write bytes are not staged.
- R11: After a write sequence, the address counter holds the last written address plus one, with the page wrap of R4 applied.
- R12: An end command with no staged bytes leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp | input | 1 | Write protect, sampled on an accepted end command |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Command code: 0 load address, 1 write byte, 2 read byte, 3 end |
| cmd_addr | input | ADDR_W | Address for the load command |
| cmd_wdata | input | 8 | Data byte for the write command |
| busy | output | 1 | Commit in progress; all commands are dropped |
| rd_valid | output | 1 | rd_data holds the byte from the previous read command |
| rd_data | output | 8 | Byte read from the array |

## Verification
Single-byte writes are spread over several pages, including offset 0, the last offset of a page and the top address. These writes separate correct row and offset handling from slips that land one page away. Multi-byte sequences that run past the end of a page show whether the write pointer wraps inside the page or carries into the row bits. Sequences longer than a page show whether the last byte wins at each offset. Sequential reads across a page edge and across the top address then prove that read addressing uses the full width. Commands sent while busy, an end command with write protect high, and an end command with nothing staged separate dropped and discarded work from a commit that happens by mistake.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_END   = 2'd3
    } eep_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COPY = 2'd1,
        ST_HOLD = 2'd2
    } eep_state_e;

endpackage

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              wr_step,
    input  logic              rd_step,
    output logic [ADDR_W-1:0] addr_q
);

    // Write steps wrap inside the page; read steps use the full width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_en) begin
            addr_q <= ld_addr;
        end else if (wr_step) begin
            addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
        end else if (rd_step) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    // R4
    row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !ld_en) |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int ROW_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_off,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              discard,
    input  logic              scan_en,
    input  logic [PAGE_W-1:0] scan_off,
    output logic              scan_valid,
    output logic [BYTE_W-1:0] scan_data,
    output logic [ROW_W-1:0]  row_q,
    output logic              pending
);

    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [BYTE_W-1:0]     mem_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_off] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            row_q <= '0;
        end else if (discard) begin
            vld_q <= '0;
        end else begin
            if (scan_en) begin
                vld_q[scan_off] <= 1'b0;
            end
            if (wr_en) begin
                vld_q[wr_off] <= 1'b1;
                row_q         <= wr_row;
            end
        end
    end

    always_comb begin
        scan_valid = vld_q[scan_off];
        scan_data  = mem_q[scan_off];
        pending    = |vld_q;
    end

    // R6
    scan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> !vld_q[$past(scan_off)]);

endmodule

// File: rtl/eep_commit_fsm.sv
module eep_commit_fsm
    import eep_pkg::*;
#(
    parameter int PAGE_W   = 8,
    parameter int HOLD_CYC = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_req,
    input  logic              pending,
    input  logic              wp,
    output logic              busy,
    output logic              discard,
    output logic              scan_en,
    output logic [PAGE_W-1:0] scan_off
);

    localparam int TW = $clog2(HOLD_CYC + 1);

    eep_state_e        state_q, state_d;
    logic [TW-1:0]     cnt_q;
    logic [PAGE_W-1:0] off_q;
    logic              go;

    assign go = end_req && pending && !wp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go)           state_d = ST_COPY;
            ST_COPY: if (&off_q)       state_d = ST_HOLD;
            ST_HOLD: if (cnt_q == '0)  state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            off_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        cnt_q <= TW'(HOLD_CYC - 1);
                        off_q <= '0;
                    end
                end
                ST_COPY: begin
                    cnt_q <= cnt_q - TW'(1);
                    off_q <= off_q + PAGE_W'(1);
                end
                ST_HOLD: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - TW'(1);
                    end
                end
                default: begin
                    cnt_q <= '0;
                    off_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        scan_en  = (state_q == ST_COPY);
        discard  = (state_q == ST_IDLE) && end_req && wp;
        scan_off = off_q;
    end

endmodule

// File: rtl/eep_array.sv
module eep_array
    import eep_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata,
    output logic              rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem_q[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
        end
    end

endmodule

// File: rtl/eep_pagewr_top.sv
module eep_pagewr_top
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 8,
    parameter int WR_CYCLES = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);

    localparam int ROW_W      = ADDR_W - PAGE_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int HOLD_CYC   = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES + 1;

    eep_op_e           op;
    logic              take, ld_en, wr_en, rd_en, end_req;
    logic [ADDR_W-1:0] addr_q;
    logic              discard, scan_en, scan_valid, pending, arr_we;
    logic [PAGE_W-1:0] scan_off;
    logic [7:0]        scan_data;
    logic [ROW_W-1:0]  row_q;

    always_comb begin
        op      = eep_op_e'(cmd_op);
        take    = cmd_valid && !busy;
        ld_en   = take && (op == OP_ADDR);
        wr_en   = take && (op == OP_WRITE);
        rd_en   = take && (op == OP_READ);
        end_req = take && (op == OP_END);
        arr_we  = scan_en && scan_valid;
    end

    eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_addr (cmd_addr),
        .wr_step (wr_en),
        .rd_step (rd_en),
        .addr_q  (addr_q)
    );

    eep_page_buf #(.PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_off     (addr_q[PAGE_W-1:0]),
        .wr_row     (addr_q[ADDR_W-1:PAGE_W]),
        .wr_data    (cmd_wdata),
        .discard    (discard),
        .scan_en    (scan_en),
        .scan_off   (scan_off),
        .scan_valid (scan_valid),
        .scan_data  (scan_data),
        .row_q      (row_q),
        .pending    (pending)
    );

    eep_commit_fsm #(.PAGE_W(PAGE_W), .HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .end_req  (end_req),
        .pending  (pending),
        .wp       (wp),
        .busy     (busy),
        .discard  (discard),
        .scan_en  (scan_en),
        .scan_off (scan_off)
    );

    eep_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (arr_we),
        .waddr  ({row_q, scan_off}),
        .wdata  (scan_data),
        .re     (rd_en),
        .raddr  (addr_q),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    // R10
    rdv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && cmd_op == 2'd2 && !busy));

    // R9
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3 && !busy && wp) |=> !busy);

    // R7
    commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && cmd_op == 2'd3 && !wp));

    // R7
    array_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

endmodule

// File: tb/tb_eep_pagewr_top.sv
module tb_eep_pagewr_top;

    localparam int ADDR_W = 11;
    localparam int HOLD   = 300;
    localparam int NVEC   = 8;

    // {address, data} pairs committed one byte at a time
    localparam logic [18:0] VEC [NVEC] = '{
        {11'h006, 8'h11}, {11'h1FF, 8'h22}, {11'h200, 8'h33}, {11'h7FF, 8'h44},
        {11'h300, 8'h77}, {11'h500, 8'hE0}, {11'h600, 8'h60}, {11'h3A7, 8'h55}
    };

    logic              clk = 1'b0;
    logic              rst_n, wp, cmd_valid;
    logic [1:0]        cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_wdata;
    logic              busy, rd_valid;
    logic [7:0]        rd_data;
    int                n_tests = 0;
    int                n_fail  = 0;
    bit                done    = 1'b0;

    always #4 clk = ~clk;

    eep_pagewr_top #(.ADDR_W(ADDR_W), .PAGE_W(8), .WR_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .wp(wp), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_at(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
        issue(2'd0, a, 8'h00);
        issue(2'd2, '0, 8'h00);
        check(req, {rd_valid, rd_data}, {1'b1, exp});
    endtask

    task automatic read_next(input string req, input logic [7:0] exp);
        issue(2'd2, '0, 8'h00);
        check(req, {rd_valid, rd_data}, {1'b1, exp});
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 3) + ((k >> 8) * 'h40));
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; wp = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 rd_valid", rd_valid, 0);
        issue(2'd1, '0, 8'hA5);
        issue(2'd3, '0, 8'h00);
        wait_idle(n);
        read_at("R1 address 0", 11'h000, 8'hA5);

        // vector table: single-byte commits across pages
        for (int i = 0; i < NVEC; i++) begin
            issue(2'd0, VEC[i][18:8], 8'h00);
            issue(2'd1, '0, VEC[i][7:0]);
            issue(2'd3, '0, 8'h00);
            wait_idle(n);
            check("R8 busy length", n, HOLD);
            read_at("R2 readback", VEC[i][18:8], VEC[i][7:0]);
        end

        // R3: reads cross a page edge and the top address
        read_at("R3 page edge a", 11'h1FF, 8'h22);
        read_next("R3 page edge b", 8'h33);
        read_at("R3 top", 11'h7FF, 8'h44);
        read_next("R3 wrap to 0", 8'hA5);

        // R4 / R11: write wraps inside page 2
        issue(2'd0, 11'h2FE, 8'h00);
        for (int k = 0; k < 4; k++) issue(2'd1, '0, 8'hB0 + 8'(k));
        issue(2'd3, '0, 8'h00);
        wait_idle(n);
        issue(2'd1, '0, 8'hB4);
        issue(2'd3, '0, 8'h00);
        wait_idle(n);
        read_at("R4 offset FE", 11'h2FE, 8'hB0);
        read_next("R4 offset FF", 8'hB1);
        read_at("R4 wrap to page start", 11'h200, 8'hB2);
        read_next("R4 second wrapped", 8'hB3);
        read_next("R11 counter after sequence", 8'hB4);
        read_at("R4 next page untouched", 11'h300, 8'h77);

        // R5: 258 bytes into page 4
        issue(2'd0, 11'h400, 8'h00);
        for (int k = 0; k < 258; k++) issue(2'd1, '0, pat(k));
        issue(2'd3, '0, 8'h00);
        wait_idle(n);
        read_at("R5 offset 0 overwritten", 11'h400, pat(256));
        read_next("R5 offset 1 overwritten", pat(257));
        read_next("R5 offset 2 kept", pat(2));
        read_at("R5 last offset", 11'h4FF, pat(255));

        // R6: partial page
        issue(2'd0, 11'h410, 8'h00);
        issue(2'd1, '0, 8'hC0);
        issue(2'd1, '0, 8'hC1);
        issue(2'd3, '0, 8'h00);
        wait_idle(n);
        read_at("R6 below untouched", 11'h40F, pat(15));
        read_next("R6 first", 8'hC0);
        read_next("R6 second", 8'hC1);
        read_next("R6 above untouched", pat(18));

        // R7: nothing reaches the array before the end command
        issue(2'd0, 11'h500, 8'h00);
        issue(2'd1, '0, 8'hD0);
        check("R7 no busy before end", busy, 0);
        read_at("R7 old data before end", 11'h500, 8'hE0);
        issue(2'd3, '0, 8'h00);
        check("R7 busy after end", busy, 1);
        wait_idle(n);
        read_at("R7 new data after end", 11'h500, 8'hD0);

        // R9: write protect discards the buffer
        issue(2'd0, 11'h600, 8'h00);
        issue(2'd1, '0, 8'hF1);
        wp = 1'b1;
        issue(2'd3, '0, 8'h00);
        check("R9 no busy with wp", busy, 0);
        wp = 1'b0;
        issue(2'd3, '0, 8'h00);
        check("R9 buffer discarded", busy, 0);
        read_at("R9 array unchanged", 11'h600, 8'h60);

        // R10 / R12: commands dropped while busy
        issue(2'd0, 11'h005, 8'h00);
        issue(2'd1, '0, 8'h99);
        issue(2'd3, '0, 8'h00);
        issue(2'd2, '0, 8'h00);
        check("R10 no read while busy", rd_valid, 0);
        issue(2'd0, 11'h000, 8'h00);
        issue(2'd1, '0, 8'h12);
        wait_idle(n);
        issue(2'd3, '0, 8'h00);
        check("R12 empty end no busy", busy, 0);
        read_next("R10 load ignored, counter at 006", 8'h11);
        read_at("R10 write ignored", 11'h000, 8'hA5);
        read_at("R10 committed byte", 11'h005, 8'h99);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule